// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block refills one cache line after a miss when the memory bus is narrower than the line. With the default parameters a line is 32 bytes and the bus carries 8 bytes per beat, so a fill takes four beats. The block latches the missed byte address and first requests the beat that contains the missed word. It then walks the remaining beats in wrapped order: it adds one to the beat index modulo the beat count, so a miss at 0x95 fetches 0x90, 0x98, 0x80 and then 0x88.

Each returned beat is written into a line buffer at its own position in the line. The first returned beat is the one the processor is waiting for, so it is also forwarded on a restart port in the same cycle it arrives, and the processor can resume while the other beats are still in flight. After the last beat the block marks the line valid and pulses a completion signal. Only one beat request is outstanding at a time. The memory side may insert any number of wait cycles before accepting a request and before returning its data.

The controller is a four-state machine:
- `S_IDLE` waits for a miss.
- `S_REQ` presents a beat request until it is accepted.
- `S_RSP` waits for that beat's data.
- `S_DONE` is the single completion cycle.

Its transitions are:
- IDLE→REQ on an accepted miss.
- REQ→RSP on request acceptance.
- RSP→REQ on a returned beat that is not the last one.
- RSP→DONE on the last returned beat.
- DONE→IDLE unconditionally.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `restart_valid`, `line_done` and `line_valid` are all 0.
- R2: A miss (`miss_valid` high while `busy` is 0) is accepted at the clock edge. From the next cycle `busy` is 1, and the first request address is the line base plus 8 times the starting beat index, which is `miss_addr[4:3]`. The low three address bits of every request are zero.
- R3: Each later request uses the previous beat index plus one, modulo 4. A miss at 0x95 requests 0x90, 0x98, 0x80 and 0x88, in that order.
- R4: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address does not change.
- R5: `restart_valid` is 1 for exactly one cycle per fill. That cycle is the one in which the first beat is returned (`mem_rsp_valid` high), and `restart_data` then equals that beat's data.
- R6: A beat returned for index k is stored in `line_data[64*k +: 64]`.
- R7: `line_done` is a one-cycle pulse in the cycle after the fourth beat is returned. `line_valid` rises in that same cycle and stays 1 until the next miss is accepted, which clears it. Neither signal is 1 while any beat is still missing.
- R8: While `busy` is 1, `miss_valid` is ignored: the request sequence and the line base of the current fill are unchanged. `busy` returns to 0 in the cycle after `line_done`.
- R9: Wait cycles before request acceptance or before data return do not change the beat order or the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | 32 | Missed byte address |
| busy | output | 1 | Fill in progress, misses ignored |
| mem_req_valid | output | 1 | Beat request valid |
| mem_req_ready | input | 1 | Memory accepts the beat request |
| mem_req_addr | output | 32 | Byte address of the requested beat (beat aligned) |
| mem_rsp_valid | input | 1 | Returned beat data valid |
| mem_rsp_data | input | 64 | Returned beat data |
| restart_valid | output | 1 | Early-restart strobe for the critical beat |
| restart_data | output | 64 | Critical beat data |
| line_valid | output | 1 | Line buffer holds a complete line |
| line_done | output | 1 | One-cycle line-complete pulse |
| line_data | output | 256 | Line buffer contents, beat k at bits 64k upward |

## Verification
The fills start at every beat position: index 2 (0x95), index 0 (a line base), index 3 (0x1F8) and index 1 (0x4C). Starting at 2 reproduces the known wrapped order. Starting at 0 cannot be told apart from an unwrapped fill, so it checks only that nothing breaks in that case. Starting at 3 forces an immediate wrap to 0. The tests also vary the wait cycles at both the request and the response step, which separates a sequencer that advances on handshakes from one that advances on time. A stray miss during a fill checks that the fill in progress is not disturbed. Returned data is tagged with the fill and the beat index, so a misplaced beat, a stale beat or a wrong restart word all show up as a data mismatch.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RSP  = 2'd2,
        S_DONE = 2'd3
    } fill_state_t;
endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
    parameter int BEATS = 4,
    parameter int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             is_first,
    output logic             is_last
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            idx_q <= load_idx;
            cnt_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + IDX_W'(1);
            cnt_q <= cnt_q + IDX_W'(1);
        end
    end

    assign idx      = idx_q;
    assign is_first = (cnt_q == '0);
    assign is_last  = (cnt_q == IDX_W'(BEATS - 1));

    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> idx == $past(idx) + IDX_W'(1)); // R3
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int BEATS  = 4,
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    we,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    set_valid,
    output logic                    line_valid,
    output logic [BEATS*DATA_W-1:0] line_data
);
    logic [BEATS-1:0] written_q;
    logic             valid_q;

    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        logic [DATA_W-1:0] beat_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                             beat_q <= '0;
            else if (we && wr_idx == IDX_W'(g))     beat_q <= wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                    written_q[g] <= 1'b0;
            else if (we && wr_idx == IDX_W'(g))     written_q[g] <= 1'b1;
        end
        assign line_data[g*DATA_W +: DATA_W] = beat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) valid_q <= 1'b0;
        else if (set_valid)  valid_q <= 1'b1;
    end

    assign line_valid = valid_q;

    AST_VALID_ALL_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> &written_q); // R7
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          miss_valid,
    input  logic [ADDR_W-1:0]             miss_addr,
    output logic                          busy,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [BEAT_BYTES*8-1:0]       mem_rsp_data,
    output logic                          restart_valid,
    output logic [BEAT_BYTES*8-1:0]       restart_data,
    output logic                          line_valid,
    output logic                          line_done,
    output logic [LINE_BYTES*8-1:0]       line_data
);
    localparam int DATA_W     = BEAT_BYTES * 8;
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int IDX_W      = $clog2(BEATS);
    localparam int OFF_W      = $clog2(BEAT_BYTES);
    localparam int LINE_OFF_W = OFF_W + IDX_W;
    localparam int BASE_W     = ADDR_W - LINE_OFF_W;

    fill_state_t      state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  idx;
    logic              is_first, is_last;
    logic              accept, advance, beat_we, set_valid;
    logic [OFF_W-1:0]  unused_low;

    assign unused_low = miss_addr[OFF_W-1:0];
    assign accept     = (state_q == S_IDLE) && miss_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (accept) base_q <= miss_addr[ADDR_W-1:LINE_OFF_W];
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        busy          = 1'b1;
        mem_req_valid = 1'b0;
        restart_valid = 1'b0;
        line_done     = 1'b0;
        advance       = 1'b0;
        beat_we       = 1'b0;
        set_valid     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                if (miss_valid) state_d = S_REQ;
            end
            S_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = S_RSP;
            end
            S_RSP: begin
                if (mem_rsp_valid) begin
                    beat_we       = 1'b1;
                    restart_valid = is_first;
                    if (is_last) begin
                        set_valid = 1'b1;
                        state_d   = S_DONE;
                    end else begin
                        advance = 1'b1;
                        state_d = S_REQ;
                    end
                end
            end
            S_DONE: begin
                line_done = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign mem_req_addr = {base_q, idx, {OFF_W{1'b0}}};
    assign restart_data = mem_rsp_data;

    cwf_beat_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_idx (miss_addr[LINE_OFF_W-1:OFF_W]),
        .advance  (advance),
        .idx      (idx),
        .is_first (is_first),
        .is_last  (is_last)
    );

    cwf_line_buf #(.BEATS(BEATS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .we         (beat_we),
        .wr_idx     (idx),
        .wr_data    (mem_rsp_data),
        .set_valid  (set_valid),
        .line_valid (line_valid),
        .line_data  (line_data)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |=> !restart_valid); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done && !busy); // R7
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q)); // R8
endmodule

// File: tb/tb_cwf_line_fill.sv
module tb_cwf_line_fill;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic         busy, mem_req_valid, restart_valid, line_valid, line_done;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [63:0]  mem_rsp_data = '0;
    logic [63:0]  restart_data;
    logic [255:0] line_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cwf_line_fill dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .restart_valid(restart_valid),
        .restart_data(restart_data), .line_valid(line_valid), .line_done(line_done),
        .line_data(line_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_word(input logic [15:0] seed, input logic [1:0] idx);
        return {16'hC0DE, seed, 30'd0, idx};
    endfunction

    // one full fill; dly = wait cycles at each step; stray = inject a miss mid-fill
    task automatic do_fill(input logic [31:0] addr, input int dly, input bit stray, input logic [15:0] seed);
        logic [31:0] base = {addr[31:5], 5'd0};
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = addr;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        chk(line_valid == 1'b0, "R7 line_valid cleared on accept", 64'(line_valid), 64'd0);
        for (int b = 0; b < 4; b++) begin
            logic [1:0]  ei = 2'(addr[4:3] + 2'(b));
            logic [31:0] ea = base | (32'(ei) << 3);
            chk(mem_req_valid == 1'b1, "R3 request valid", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == ea, b == 0 ? "R2 first request addr" : "R3 wrapped request addr",
                64'(mem_req_addr), 64'(ea));
            for (int w = 0; w < dly; w++) begin
                if (stray && b == 1 && w == 0) begin
                    miss_valid = 1'b1; miss_addr = addr ^ 32'h0000_1010;
                end
                @(negedge clk);
                miss_valid = 1'b0;
                chk(mem_req_valid && mem_req_addr == ea, "R4 request held while not ready",
                    64'(mem_req_addr), 64'(ea));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R9 no request while awaiting data", 64'(mem_req_valid), 64'd0);
            for (int w = 0; w < dly; w++) begin
                @(negedge clk);
                chk(restart_valid == 1'b0, "R5 no restart during wait", 64'(restart_valid), 64'd0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = beat_word(seed, ei);
            #1;
            chk(restart_valid == (b == 0), "R5 restart strobe on first beat only",
                64'(restart_valid), 64'(b == 0));
            if (b == 0)
                chk(restart_data == beat_word(seed, ei), "R5 restart data",
                    restart_data, beat_word(seed, ei));
            chk(!line_done && !line_valid, "R7 no completion before last beat",
                64'({line_done, line_valid}), 64'd0);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        chk(line_done == 1'b1 && line_valid == 1'b1, "R7 done and valid after fourth beat",
            64'({line_done, line_valid}), 64'd3);
        chk(busy == 1'b1, "R8 busy during done cycle", 64'(busy), 64'd1);
        @(negedge clk);
        chk(line_done == 1'b0, "R7 done is one cycle", 64'(line_done), 64'd0);
        chk(busy == 1'b0 && line_valid == 1'b1, "R8 idle after done, R7 line kept valid",
            64'({busy, line_valid}), 64'd1);
        for (int k = 0; k < 4; k++)
            chk(line_data[64*k +: 64] == beat_word(seed, 2'(k)), "R6 beat stored at its index",
                line_data[64*k +: 64], beat_word(seed, 2'(k)));
    endtask

    task automatic test_reset();
        chk(!busy && !mem_req_valid && !restart_valid && !line_done && !line_valid,
            "R1 reset outputs", 64'({busy, mem_req_valid, restart_valid, line_done, line_valid}), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        do_fill(32'h0000_0095, 0, 1'b0, 16'h0001); // R3 known wrapped order
        do_fill(32'h0000_0080, 2, 1'b0, 16'h0002); // R9 waits, start at index 0
        do_fill(32'h0000_01F8, 3, 1'b1, 16'h0003); // R8 stray miss, start at index 3
        do_fill(32'h0000_004C, 1, 1'b1, 16'h0004); // R9 start at index 1
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule